// File: doc/BRIEF.md
# Alternate-Byte Peripheral Transfer Sequencer

This block carries out one move-to/from-peripheral instruction for a 32-bit processor core. It spreads the bytes of a data register over every second byte address in memory. An 8-bit peripheral that sits on one byte lane of a 16-bit bus then sees each byte at its own register. The transfer runs in either direction: a store sends register bytes to memory, and a load gathers memory bytes into the register.

The surrounding decoder presents the opcode word and the 16-bit extension displacement. The block returns the two register indices taken from the opcode, so the register file can supply the address register value and the data register value. When `start` is pulsed, the sequencer issues one single-byte request at a time and waits for each acknowledge. It finishes with a one-cycle `done` pulse. On a load, a single write-back of the assembled register value accompanies that pulse.

Top module: `altb_xfer_seq`

## Requirements
- R1: An opcode is legal when (opcode & 0xF138) == 0x0108. A start with an illegal opcode raises `illegal` for exactly the next cycle. It issues no memory request, no `done` and no write-back.
- R2: `dreg_sel` always equals opcode bits 11:9, and `areg_sel` always equals opcode bits 2:0.
- R3: The first byte address is `areg_val` plus the sign-extended 16-bit `disp`, taken modulo 2^32.
- R4: Each later byte address is the previous one plus 2, wrapping modulo 2^32. Opcode bit 6 = 1 moves four bytes, and bit 6 = 0 moves two bytes.
- R5: With opcode bit 7 = 1 (store), `mem_we` is 1. The bytes go out most significant first: bits 31:24, 23:16, 15:8, 7:0 for four bytes, or bits 15:8, 7:0 for two.
- R6: With opcode bit 7 = 0 (load), the k-th byte acknowledged goes into the register lane that a store would have sent k-th. `wb_en` pulses once together with `done`, carrying `wb_idx` = opcode bits 11:9 and the merged value. A two-byte load keeps bits 31:16 of the original register value.
- R7: Only one request is outstanding at a time. While `mem_req` is high without `mem_ack`, the address and write data hold steady, and the sequencer advances only on an acknowledge.
- R8: `busy` is high from the cycle after an accepted legal start until the last acknowledge. `done` then pulses for exactly one cycle.
- R9: A start while `busy` is high is ignored. The running transfer keeps its addresses, its data and its byte count, and `illegal` is not raised.
- R10: A store never asserts `wb_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing the presented opcode |
| opcode | input | 16 | Instruction word |
| disp | input | 16 | Signed extension displacement |
| areg_val | input | 32 | Value of the selected address register |
| dreg_val | input | 32 | Value of the selected data register |
| areg_sel | output | 3 | Address register index decoded from the opcode |
| dreg_sel | output | 3 | Data register index decoded from the opcode |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for a start with a non-matching opcode |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | 1 = write byte, 0 = read byte |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| wb_en | output | 1 | Data register write-back strobe |
| wb_idx | output | 3 | Data register index to write |
| wb_data | output | 32 | Merged register value |

## Verification
The hardest case to reach from the ports is a second start that lands while a transfer is stalled between acknowledges. In that situation a careless sequencer reloads its address, its count or its data. The bench produces it by giving the memory model a one-cycle acknowledge latency and then holding `start` for one more cycle after acceptance. That extra cycle carries an illegal opcode and a different address register value, so any reaction would show up either as an `illegal` pulse or as wrong addresses and merged data. Address wrap past 2^32 and negative displacements are covered by table entries whose expected addresses the bench computes with its own arithmetic.

// File: rtl/altb_pkg.sv
package altb_pkg;

    localparam int OP_W = 16;
    localparam logic [OP_W-1:0] OP_MASK  = 16'hF138;
    localparam logic [OP_W-1:0] OP_MATCH = 16'h0108;

    typedef enum logic {
        DIR_LOAD  = 1'b0,
        DIR_STORE = 1'b1
    } xfer_dir_e;

    typedef enum logic {
        SZ_WORD = 1'b0,
        SZ_LONG = 1'b1
    } xfer_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic       legal;
        xfer_dir_e  dir;
        xfer_size_e size;
        logic [2:0] dreg;
        logic [2:0] areg;
    } op_fields_t;

    function automatic op_fields_t decode_op(input logic [OP_W-1:0] op);
        op_fields_t f;
        f.legal = ((op & OP_MASK) == OP_MATCH);
        f.dir   = op[7] ? DIR_STORE : DIR_LOAD;
        f.size  = op[6] ? SZ_LONG : SZ_WORD;
        f.dreg  = op[11:9];
        f.areg  = op[2:0];
        return f;
    endfunction

endpackage

// File: rtl/altb_decode.sv
module altb_decode
    import altb_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output op_fields_t      fields
);

    always_comb begin
        fields = decode_op(opcode);
    end

endmodule

// File: rtl/altb_lane_mux.sv
module altb_lane_mux #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int LANE_W = 2
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [LANE_W-1:0] lane,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic [DATA_W-1:0] word_merged
);

    localparam int NLANES = DATA_W / BYTE_W;

    assign byte_out = word_in[lane*BYTE_W +: BYTE_W];

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign word_merged[g*BYTE_W +: BYTE_W] =
            (lane == LANE_W'(g)) ? byte_in : word_in[g*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/altb_xfer_seq.sv
module altb_xfer_seq
    import altb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DISP_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] areg_val,
    input  logic [DATA_W-1:0] dreg_val,
    output logic [2:0]        areg_sel,
    output logic [2:0]        dreg_sel,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              wb_en,
    output logic [2:0]        wb_idx,
    output logic [DATA_W-1:0] wb_data
);

    localparam int NLANES = DATA_W / BYTE_W;
    localparam int LANE_W = $clog2(NLANES);
    localparam logic [LANE_W-1:0] LANE_LONG = LANE_W'(NLANES - 1);
    localparam logic [LANE_W-1:0] LANE_WORD = LANE_W'(NLANES / 2 - 1);
    localparam logic [ADDR_W-1:0] STRIDE    = ADDR_W'(2);

    op_fields_t  dec;
    seq_state_e  state_q;
    xfer_dir_e   dir_q;
    logic [LANE_W-1:0] lane_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] merged;
    logic [2:0]        idx_q;
    logic              done_q;
    logic              illegal_q;
    logic              accept;
    logic              last_byte;
    logic [ADDR_W-1:0] first_addr;

    altb_decode u_decode (
        .opcode (opcode),
        .fields (dec)
    );

    altb_lane_mux #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W),
        .LANE_W (LANE_W)
    ) u_lane (
        .word_in     (data_q),
        .lane        (lane_q),
        .byte_in     (mem_rdata),
        .byte_out    (mem_wdata),
        .word_merged (merged)
    );

    assign accept     = start && (state_q == ST_IDLE);
    assign last_byte  = (lane_q == '0);
    assign first_addr = areg_val + ADDR_W'({{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp});

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            dir_q     <= DIR_LOAD;
            lane_q    <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            idx_q     <= '0;
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (dec.legal) begin
                            state_q <= ST_XFER;
                            dir_q   <= dec.dir;
                            idx_q   <= dec.dreg;
                            addr_q  <= first_addr;
                            data_q  <= dreg_val;
                            lane_q  <= (dec.size == SZ_LONG) ? LANE_LONG : LANE_WORD;
                        end else begin
                            illegal_q <= 1'b1;
                        end
                    end
                end
                ST_XFER: begin
                    if (mem_ack) begin
                        if (dir_q == DIR_LOAD) begin
                            data_q <= merged;
                        end
                        if (last_byte) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            lane_q <= lane_q - LANE_W'(1);
                            addr_q <= addr_q + STRIDE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign areg_sel = dec.areg;
    assign dreg_sel = dec.dreg;
    assign busy     = (state_q == ST_XFER);
    assign mem_req  = busy;
    assign mem_we   = busy && (dir_q == DIR_STORE);
    assign mem_addr = addr_q;
    assign done     = done_q;
    assign illegal  = illegal_q;
    assign wb_en    = done_q && (dir_q == DIR_LOAD);
    assign wb_idx   = idx_q;
    assign wb_data  = data_q;

    assert_hold_while_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    assert_stride_two_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !last_byte) |=> (mem_addr == $past(mem_addr) + STRIDE));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_illegal_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!mem_req && !done && !wb_en));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !mem_ack) |=> (!illegal && $stable(mem_addr)));

    assert_wb_only_done_R6: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (done && !busy));

endmodule

// File: tb/altb_xfer_seq_tb.sv
`timescale 1ns/100ps
module altb_xfer_seq_tb;

    typedef struct packed {
        logic [15:0] op;
        logic [15:0] disp;
        logic [31:0] areg;
        logic [31:0] dreg;
        logic [31:0] rd;
        logic [1:0]  lat;
    } vec_t;

    localparam int NVEC = 6;
    // op fields: bit7 dir (1 store), bit6 size (1 long), 11:9 dreg, 2:0 areg
    localparam vec_t VECS [NVEC] = '{
        '{16'h07CA, 16'h0010, 32'h0000_2000, 32'hA1B2_C3D4, 32'h0,          2'd0},
        '{16'h0B8F, 16'hFFFE, 32'h0000_1000, 32'h1234_5678, 32'h0,          2'd1},
        '{16'h0149, 16'h0004, 32'h0040_0000, 32'h0000_0000, 32'h9988_7766, 2'd2},
        '{16'h0F08, 16'h0000, 32'h0000_3000, 32'hCAFE_BABE, 32'h1122_0000, 2'd0},
        '{16'h05C9, 16'h0002, 32'hFFFF_FFFC, 32'h0F1E_2D3C, 32'h0,          2'd1},
        '{16'h0D0C, 16'h7FFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h5AA5_0000, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] opcode;
    logic [15:0] disp;
    logic [31:0] areg_val;
    logic [31:0] dreg_val;
    logic [2:0]  areg_sel;
    logic [2:0]  dreg_sel;
    logic        busy;
    logic        done;
    logic        illegal;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_ack;
    logic        wb_en;
    logic [2:0]  wb_idx;
    logic [31:0] wb_data;

    int checks = 0;
    int failures = 0;

    logic [31:0] cur_rd  = '0;
    logic [1:0]  cur_lat = '0;

    int          n_acc    = 0;
    int          hold_err = 0;
    int          wait_cnt = 0;
    bit          pending  = 0;
    logic [31:0] seen_addr;
    logic [7:0]  seen_wd;
    logic [31:0] log_addr [64];
    logic [7:0]  log_wd   [64];
    logic        log_we   [64];
    int          rd_idx   = 0;

    always #2.5 clk = ~clk;

    altb_xfer_seq u_dut (
        .clk (clk), .rst (rst), .start (start), .opcode (opcode), .disp (disp),
        .areg_val (areg_val), .dreg_val (dreg_val), .areg_sel (areg_sel),
        .dreg_sel (dreg_sel), .busy (busy), .done (done), .illegal (illegal),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .mem_ack (mem_ack),
        .wb_en (wb_en), .wb_idx (wb_idx), .wb_data (wb_data)
    );

    // byte memory model: one outstanding access, ack after cur_lat waits
    always @(negedge clk) begin
        if (mem_req) begin
            if (!pending) begin
                pending   = 1;
                wait_cnt  = 0;
                seen_addr = mem_addr;
                seen_wd   = mem_wdata;
            end
            if (wait_cnt == int'(cur_lat)) begin
                if (mem_addr !== seen_addr || (mem_we && mem_wdata !== seen_wd))
                    hold_err++;
                log_addr[n_acc % 64] = mem_addr;
                log_wd[n_acc % 64]   = mem_wdata;
                log_we[n_acc % 64]   = mem_we;
                mem_rdata = cur_rd[31 - 8*rd_idx -: 8];
                rd_idx    = (rd_idx + 1) % 4;
                n_acc++;
                mem_ack = 1'b1;
                pending = 0;
            end else begin
                mem_ack = 1'b0;
                wait_cnt++;
            end
        end else begin
            mem_ack = 1'b0;
            pending = 0;
            rd_idx  = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input bit inject);
        int          n;
        int          a0;
        int          h0;
        int          cyc;
        bit          saw_illegal;
        logic [31:0] base;
        logic [31:0] exp_wb;
        n    = v.op[6] ? 4 : 2;
        base = v.areg + {{16{v.disp[15]}}, v.disp};
        a0   = n_acc;
        h0   = hold_err;
        saw_illegal = 0;
        cur_rd  = v.rd;
        cur_lat = v.lat;
        @(negedge clk);
        opcode = v.op; disp = v.disp; areg_val = v.areg; dreg_val = v.dreg; start = 1'b1;
        #1;
        chk(dreg_sel == v.op[11:9], "R2", "dreg_sel", 32'(dreg_sel), 32'(v.op[11:9]));
        chk(areg_sel == v.op[2:0],  "R2", "areg_sel", 32'(areg_sel), 32'(v.op[2:0]));
        @(negedge clk);
        chk(busy == 1'b1, "R8", "busy after start", 32'(busy), 32'd1);
        if (inject) begin
            // R9: second start mid-transfer with an illegal opcode and other base
            start = 1'b1; opcode = 16'h0000; areg_val = 32'hDEAD_0000; dreg_val = 32'h0;
            @(negedge clk);
            saw_illegal = saw_illegal | illegal;
        end
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 60) begin
            @(negedge clk);
            saw_illegal = saw_illegal | illegal;
            cyc++;
        end
        chk(done == 1'b1, "R8", "done seen", 32'(done), 32'd1);
        chk(busy == 1'b0, "R8", "busy low with done", 32'(busy), 32'd0);
        if (inject)
            chk(!saw_illegal, "R9", "illegal during busy start", 32'(saw_illegal), 32'd0);
        chk(n_acc - a0 == n, "R4", "byte count", 32'(n_acc - a0), 32'(n));
        chk(hold_err == h0, "R7", "request held until ack", 32'(hold_err - h0), 32'd0);
        exp_wb = v.dreg;
        for (int i = 0; i < n; i++) begin
            chk(log_addr[(a0 + i) % 64] == base + 32'(2*i), (i == 0) ? "R3" : "R4",
                "byte address", log_addr[(a0 + i) % 64], base + 32'(2*i));
            chk(log_we[(a0 + i) % 64] == v.op[7], "R5", "write enable",
                32'(log_we[(a0 + i) % 64]), 32'(v.op[7]));
            if (v.op[7])
                chk(log_wd[(a0 + i) % 64] == v.dreg[(n-1-i)*8 +: 8], "R5", "store byte order",
                    32'(log_wd[(a0 + i) % 64]), 32'(v.dreg[(n-1-i)*8 +: 8]));
            exp_wb[(n-1-i)*8 +: 8] = v.rd[31 - 8*i -: 8];
        end
        if (v.op[7]) begin
            chk(wb_en == 1'b0, "R10", "no write-back on store", 32'(wb_en), 32'd0);
        end else begin
            chk(wb_en == 1'b1, "R6", "write-back strobe", 32'(wb_en), 32'd1);
            chk(wb_idx == v.op[11:9], "R6", "write-back index", 32'(wb_idx), 32'(v.op[11:9]));
            chk(wb_data == exp_wb, "R6", "merged value", wb_data, exp_wb);
        end
        @(negedge clk);
        chk(done == 1'b0 && wb_en == 1'b0, "R8", "done single cycle",
            32'({done, wb_en}), 32'd0);
    endtask

    task automatic run_illegal(input logic [15:0] op);
        int a0;
        a0 = n_acc;
        @(negedge clk);
        opcode = op; disp = 16'h0; areg_val = 32'h100; dreg_val = 32'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(illegal == 1'b1, "R1", "illegal pulse", 32'(illegal), 32'd1);
        chk(busy == 1'b0 && mem_req == 1'b0, "R1", "no access on illegal",
            32'({busy, mem_req}), 32'd0);
        @(negedge clk);
        chk(illegal == 1'b0 && done == 1'b0, "R1", "illegal single cycle, no done",
            32'({illegal, done}), 32'd0);
        chk(n_acc == a0, "R1", "bus access count", 32'(n_acc - a0), 32'd0);
    endtask

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; opcode = '0; disp = '0; areg_val = '0; dreg_val = '0;
        mem_ack = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, illegal, mem_req, wb_en} == 5'b0, "R8", "reset state",
            32'({busy, done, illegal, mem_req, wb_en}), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i], 1'b0);
        end

        run_illegal(16'h0000);
        run_illegal(16'h01C0);
        run_illegal(16'h8108);

        // R9: start during a stalled long load
        run_vec('{16'h0149, 16'h0006, 32'h0000_5000, 32'h0BAD_F00D, 32'h0102_0304, 2'd1}, 1'b1);

        // R2 across all index values
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            opcode = 16'h0108 | 16'(k << 9) | 16'(7 - k);
            #1;
            chk(dreg_sel == 3'(k) && areg_sel == 3'(7 - k), "R2", "index decode sweep",
                32'({dreg_sel, areg_sel}), 32'({3'(k), 3'(7 - k)}));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule